// File: doc/BRIEF.md
# Multi-Mode Host Port Interface

This block is a slave port through which an external host reaches a 32-bit on-chip memory bus. On the host side there is a chip select, an access strobe, a read/write line, a 2-bit register select, a half-select line, a 16-bit direct address and a data bus, plus a ready output. On the chip side the block issues single-word memory requests. Inside, it holds an address register, a control register and a data path that can step the address and fetch ahead into a small read FIFO.

A static mode input picks one of three host modes. Half-word mode carries each 32-bit word as two 16-bit halves on data lines [15:0]. Full-word mode moves a whole word in a single strobe. Window mode treats the port like an asynchronous SRAM. The host puts a byte address on the direct address pins, and the control register supplies the address bits above it.

Host accesses are synchronous to `clk`. An access is taken on a rising edge where `hp_cs`, `hp_strobe` and `hp_rdy` are all high. The memory request port is valid/ready. Once `mem_req_valid` is raised it stays high, with address, write flag and data held, until a cycle in which `mem_req_ready` is high. Write requests complete at that handshake. A read request is answered by exactly one `mem_rsp_valid` pulse in some later cycle. There is never more than one request outstanding.

Top module: `hpi_port`

## Requirements
- R1: After reset `hp_rdy` is 1, `mem_req_valid` is 0, and the control and address registers both read as 0.
- R2: `cfg_mode` selects the host mode: 0 is half-word, 1 is full-word, 2 is window. In the two multiplexed modes, `hp_sel` picks the target: 0 is the control register (8 bits kept, read back zero-extended), 1 is the address register, 2 is data with post-increment, 3 is data with a fixed address. In full-word mode a control or address access completes in one strobe and issues no memory request.
- R3: A full-word data write issues one memory write of `hp_wdata` at the address register. With select 2 the address register then grows by 4. With select 3 it is unchanged.
- R4: Successive select-2 reads return the words at A, A+4, A+8 and so on, and the address register advances by 4 for every word read.
- R5: While a post-increment read stream is open, the block prefetches ahead until the FIFO holds FIFO_DEPTH words. After a first read from a fresh stream with the host idle, exactly 1+FIFO_DEPTH memory reads have been issued. `hp_rdy` stays low while the FIFO is empty.
- R6: Writing the address register, any data write, or a select-3 read discards prefetched words. The next read returns the word at the new address. A select-3 read leaves the address register unchanged.
- R7: In half-word mode a write sends the low half while `hp_half`=0 and then the high half while `hp_half`=1. The write, whether to memory or to a register, takes effect only after the second half.
- R8: In half-word mode a read with `hp_half`=0 performs the 32-bit read and returns bits [15:0]. A following read with `hp_half`=1 returns bits [31:16] and issues no memory access. `hp_rdata[31:16]` is 0 in this mode.
- R9: In window mode `hp_sel` is ignored. Every access goes to memory at address {control register, `hp_addr`}, and the address register does not change.
- R10: `hp_rdy` is low while a memory request is pending, and stays low until the grant for a write or the response data for a read.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with address, write flag and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Host mode: 0 half-word, 1 full-word, 2 window |
| hp_cs | input | 1 | Host chip select |
| hp_strobe | input | 1 | Host access strobe |
| hp_rnw | input | 1 | 1 = read, 0 = write |
| hp_sel | input | 2 | Register select in multiplexed modes |
| hp_half | input | 1 | Half select in half-word mode (0 first, 1 second) |
| hp_addr | input | 16 | Byte address within the window (window mode) |
| hp_wdata | input | 32 | Host write data |
| hp_rdata | output | 32 | Host read data, valid when `hp_rdy` is high after a read |
| hp_rdy | output | 1 | Port can take an access; low while work is pending |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request grant |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 24 | Request byte address |
| mem_req_wdata | output | 32 | Request write data |
| mem_rsp_valid | input | 1 | Read response pulse |
| mem_rsp_data | input | 32 | Read response data |

## Verification
The checks assume that `cfg_mode` changes only while the port is idle and no prefetch is in flight. They also assume that `mem_rsp_valid` pulses once per granted read and never at any other time. In half-word mode they assume the host always sends the `hp_half`=0 half before the `hp_half`=1 half of the same access. The bench keeps to these rules as follows. It models the memory with one response per granted read. It switches modes only after a select-3 read or an address write has closed any stream. Every host access waits for `hp_rdy` and is issued in the documented half order. The grant latency is varied so that stalled requests are exercised.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  typedef enum logic [1:0] {
    MODE_HALF = 2'd0,
    MODE_FULL = 2'd1,
    MODE_WIN  = 2'd2
  } hpi_mode_e;

  typedef enum logic [2:0] {
    K_CTL  = 3'd0,
    K_ADDR = 3'd1,
    K_DINC = 3'd2,
    K_DFIX = 3'd3,
    K_WIN  = 3'd4
  } hpi_kind_e;

  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DINC = 2'd2;
endpackage

// File: rtl/hpi_host_decode.sv
module hpi_host_decode
  import hpi_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          cs,
  input  logic          strobe,
  input  logic          rdy,
  input  logic          rnw,
  input  logic          half,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic          acc,
  output logic          go,
  output logic          read_hi,
  output hpi_kind_e     kind,
  output logic [DW-1:0] wd
);
  localparam int HW = DW / 2;

  logic          hmode;
  logic [HW-1:0] lo_q;

  assign hmode   = (mode == MODE_HALF);
  assign acc     = cs & strobe & rdy;
  // half mode: writes act on the second half, reads on the first
  assign go      = acc & (!hmode | (rnw ? !half : half));
  assign read_hi = acc & hmode & rnw & half;
  assign wd      = hmode ? {wdata[HW-1:0], lo_q} : wdata;

  always_comb begin
    if (mode == MODE_WIN) kind = K_WIN;
    else begin
      case (sel)
        SEL_CTL:  kind = K_CTL;
        SEL_ADDR: kind = K_ADDR;
        SEL_DINC: kind = K_DINC;
        default:  kind = K_DFIX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else if (acc && hmode && !rnw && !half) lo_q <= wdata[HW-1:0];
  end
endmodule

// File: rtl/hpi_rdfifo.sv
module hpi_rdfifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = store[rp];
  assign empty = (cnt == '0);
  assign count = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) store[wp] <= push_data;
  end
endmodule

// File: rtl/hpi_req_master.sv
module hpi_req_master #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          issue_we,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] issue_wdata,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          fill,
  output logic [DW-1:0] fill_data
);
  logic vld_q, wait_q;

  assign mem_req_valid = vld_q;
  assign busy          = vld_q | wait_q;
  assign fill          = wait_q & mem_rsp_valid;
  assign fill_data     = mem_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0; wait_q <= 1'b0; mem_req_we <= 1'b0;
      mem_req_addr <= '0; mem_req_wdata <= '0;
    end else begin
      if (issue && !busy) begin
        vld_q         <= 1'b1;
        mem_req_we    <= issue_we;
        mem_req_addr  <= issue_addr;
        mem_req_wdata <= issue_wdata;
      end else if (vld_q && mem_req_ready) begin
        vld_q <= 1'b0;
        if (!mem_req_we) wait_q <= 1'b1;
      end
      if (fill) wait_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hpi_port.sv
module hpi_port
  import hpi_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_mode,
  input  logic          hp_cs,
  input  logic          hp_strobe,
  input  logic          hp_rnw,
  input  logic [1:0]    hp_sel,
  input  logic          hp_half,
  input  logic [15:0]   hp_addr,
  input  logic [DW-1:0] hp_wdata,
  output logic [DW-1:0] hp_rdata,
  output logic          hp_rdy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam int WIN_W  = 16;
  localparam int PAGE_W = AW - WIN_W;
  localparam int HW     = DW / 2;
  localparam int CW     = $clog2(FIFO_DEPTH+1);
  localparam logic [AW-1:0] STEP = AW'(DW/8);

  typedef enum logic {S_IDLE, S_RDWAIT} st_e;

  st_e             st_q;
  logic [PAGE_W-1:0] ctl_q;
  logic [AW-1:0]   addr_q, fetch_q;
  logic            pf_on, inc_q;
  logic [DW-1:0]   rd_word, rdata_q;

  logic            acc, go, read_hi;
  hpi_kind_e       kind;
  logic [DW-1:0]   wd;
  logic            busy, fill;
  logic [DW-1:0]   fill_data, head;
  logic            empty;
  logic [CW-1:0]   count;

  logic            issue, iss_we, pf_iss, flush, pop, pop_inc;
  logic [AW-1:0]   iss_addr;
  logic            hmode;

  assign hmode    = (cfg_mode == MODE_HALF);
  assign hp_rdy   = (st_q == S_IDLE) && !busy;
  assign hp_rdata = rdata_q;

  function automatic logic [DW-1:0] fmt(input logic [DW-1:0] w, input logic h);
    return h ? {{(DW-HW){1'b0}}, w[HW-1:0]} : w;
  endfunction

  hpi_host_decode #(.DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .cs(hp_cs), .strobe(hp_strobe),
    .rdy(hp_rdy), .rnw(hp_rnw), .half(hp_half), .sel(hp_sel), .wdata(hp_wdata),
    .acc(acc), .go(go), .read_hi(read_hi), .kind(kind), .wd(wd)
  );

  hpi_req_master #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_we(iss_we),
    .issue_addr(iss_addr), .issue_wdata(wd), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .fill(fill), .fill_data(fill_data)
  );

  hpi_rdfifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(fill), .push_data(fill_data),
    .pop(pop), .head(head), .empty(empty), .count(count)
  );

  // request issue, flush and pop selection
  always_comb begin
    issue = 1'b0; iss_we = 1'b0; iss_addr = addr_q;
    pf_iss = 1'b0; flush = 1'b0; pop = 1'b0; pop_inc = inc_q;
    if (go) begin
      pop_inc = (kind == K_DINC);
      case (kind)
        K_DINC, K_DFIX: begin
          if (!hp_rnw) begin
            flush = 1'b1; issue = 1'b1; iss_we = 1'b1;
          end else if (kind == K_DINC) begin
            if (pf_on && !empty) pop = 1'b1;
            else if (!pf_on) flush = 1'b1;
          end else begin
            flush = 1'b1; issue = 1'b1;
          end
        end
        K_WIN: begin
          flush = 1'b1; issue = 1'b1; iss_we = !hp_rnw;
          iss_addr = {ctl_q, hp_addr};
        end
        K_ADDR: if (!hp_rnw) flush = 1'b1;
        default: ;
      endcase
    end else if (st_q == S_RDWAIT && !empty) begin
      pop = 1'b1;
    end else if (pf_on && !busy && count < CW'(FIFO_DEPTH) && cfg_mode != MODE_WIN) begin
      issue = 1'b1; pf_iss = 1'b1; iss_addr = fetch_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; ctl_q <= '0; addr_q <= '0; fetch_q <= '0;
      pf_on <= 1'b0; inc_q <= 1'b0; rd_word <= '0; rdata_q <= '0;
    end else begin
      if (pf_iss) fetch_q <= fetch_q + STEP;
      if (pop) begin
        rd_word <= head;
        rdata_q <= fmt(head, hmode);
        if (pop_inc) addr_q <= addr_q + STEP;
        st_q <= S_IDLE;
      end
      if (read_hi) rdata_q <= {{(DW-HW){1'b0}}, rd_word[DW-1:HW]};
      if (go) begin
        case (kind)
          K_CTL: begin
            if (hp_rnw) begin
              rd_word <= DW'(ctl_q);
              rdata_q <= fmt(DW'(ctl_q), hmode);
            end else ctl_q <= wd[PAGE_W-1:0];
          end
          K_ADDR: begin
            if (hp_rnw) begin
              rd_word <= DW'(addr_q);
              rdata_q <= fmt(DW'(addr_q), hmode);
            end else begin
              addr_q <= wd[AW-1:0];
              pf_on  <= 1'b0;
            end
          end
          K_DINC: begin
            if (!hp_rnw) begin
              addr_q <= addr_q + STEP;
              pf_on  <= 1'b0;
            end else if (!pf_on) begin
              pf_on <= 1'b1; fetch_q <= addr_q;
              st_q <= S_RDWAIT; inc_q <= 1'b1;
            end else if (empty) begin
              st_q <= S_RDWAIT; inc_q <= 1'b1;
            end
          end
          default: begin
            pf_on <= 1'b0;
            if (hp_rnw) begin
              st_q <= S_RDWAIT; inc_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/hpi_port_chk.sv
module hpi_port_chk #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_mode,
  input logic          hp_cs,
  input logic          hp_strobe,
  input logic          hp_rdy,
  input logic          hp_rnw,
  input logic          hp_half,
  input logic [1:0]    hp_sel,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic [AW-17:0] page
);
  logic take;
  assign take = hp_cs && hp_strobe && hp_rdy;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)); // R11

  AST_PENDING_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !hp_rdy); // R10

  AST_LOW_HALF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0) && take && !hp_rnw && !hp_half |=> !mem_req_valid); // R7

  AST_WINDOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2) && mem_req_valid |-> mem_req_addr[AW-1:16] == page); // R9

  AST_REG_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1) && take && !hp_sel[1] |=> !mem_req_valid); // R2
endmodule

bind hpi_port hpi_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .hp_cs(hp_cs),
  .hp_strobe(hp_strobe), .hp_rdy(hp_rdy), .hp_rnw(hp_rnw), .hp_half(hp_half),
  .hp_sel(hp_sel), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .page(ctl_q)
);

// File: tb/hpi_port_test.sv
module hpi_port_test;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 2'd1;
  logic hp_cs = 0, hp_strobe = 0, hp_rnw = 0, hp_half = 0;
  logic [1:0] hp_sel = 0;
  logic [15:0] hp_addr = 0;
  logic [DW-1:0] hp_wdata = 0, hp_rdata;
  logic hp_rdy, mem_req_valid, mem_req_we;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata, mem_rsp_data = 0;

  always #2.5 clk = ~clk;

  hpi_port #(.AW(AW), .DW(DW), .FIFO_DEPTH(DEPTH)) uut (.*);

  int n_chk = 0, n_err = 0;
  int lat = 2, gcnt = 0, n_rd = 0, n_wr = 0;
  int v_rdy = 0, v_hold = 0;
  logic [AW-1:0] last_rd = 0, last_wr = 0, prev_addr = 0;
  logic rsp_pend = 0, prev_stall = 0;
  logic [DW-1:0] rsp_d = 0;
  logic [DW-1:0] mem [256];

  function automatic logic [31:0] fval(input int i);
    logic [7:0] b = 8'(i);
    return {8'hA5, b, ~b, b ^ 8'h3C};
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = fval(i);

  // memory model and bus monitors
  always @(negedge clk) begin
    if (prev_stall && !(mem_req_valid && mem_req_addr == prev_addr)) v_hold++;
    mem_rsp_valid = rsp_pend; mem_rsp_data = rsp_d; rsp_pend = 0;
    if (mem_req_valid) begin
      mem_req_ready = (gcnt >= lat);
      gcnt++;
    end else mem_req_ready = 0;
    if (mem_req_valid && hp_rdy) v_rdy++;
    prev_stall = mem_req_valid && !mem_req_ready;
    prev_addr  = mem_req_addr;
  end

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      gcnt = 0;
      if (mem_req_we) begin
        mem[mem_req_addr[9:2]] = mem_req_wdata; n_wr++; last_wr = mem_req_addr;
      end else begin
        rsp_pend = 1; rsp_d = mem[mem_req_addr[9:2]]; n_rd++; last_rd = mem_req_addr;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host(input logic rnw, input logic [1:0] sel, input logic half,
                      input logic [15:0] a, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    while (!hp_rdy) @(negedge clk);
    hp_cs = 1; hp_strobe = 1; hp_rnw = rnw; hp_sel = sel; hp_half = half;
    hp_addr = a; hp_wdata = wd;
    @(negedge clk);
    hp_cs = 0; hp_strobe = 0;
    while (!hp_rdy) @(negedge clk);
    rd = hp_rdata;
  endtask

  logic [31:0] r;
  int snap;

  task automatic t_reset();
    chk("R1 rdy", 32'(hp_rdy), 1);
    chk("R1 req", 32'(mem_req_valid), 0);
    host(1, 2'd0, 0, 0, 0, r); chk("R1 ctl", r, 0);
    host(1, 2'd1, 0, 0, 0, r); chk("R1 addr", r, 0);
  endtask

  task automatic t_regs();
    host(0, 2'd0, 0, 0, 32'hABCD1234, r);
    host(1, 2'd0, 0, 0, 0, r); chk("R2 ctl readback", r, 32'h34);
    host(0, 2'd1, 0, 0, 32'h100, r);
    host(1, 2'd1, 0, 0, 0, r); chk("R2 addr readback", r, 32'h100);
    chk("R2 no mem traffic", 32'(n_rd + n_wr), 0);
  endtask

  task automatic t_full_write();
    host(0, 2'd1, 0, 0, 32'h40, r);
    host(0, 2'd2, 0, 0, 32'hDEAD0001, r);
    chk("R3 inc write data", mem[8'h10], 32'hDEAD0001);
    host(1, 2'd1, 0, 0, 0, r); chk("R3 addr after inc write", r, 32'h44);
    host(0, 2'd3, 0, 0, 32'hBEEF0002, r);
    chk("R3 fixed write data", mem[8'h11], 32'hBEEF0002);
    host(1, 2'd1, 0, 0, 0, r); chk("R3 addr after fixed write", r, 32'h44);
    chk("R3 write count", 32'(n_wr), 2);
  endtask

  task automatic t_stream();
    host(0, 2'd1, 0, 0, 32'h80, r);
    snap = n_rd;
    host(1, 2'd2, 0, 0, 0, r); chk("R4 word0", r, fval(8'h20));
    repeat (60) @(negedge clk);
    chk("R5 prefetch count", 32'(n_rd - snap), 32'(1 + DEPTH));
    host(1, 2'd2, 0, 0, 0, r); chk("R4 word1", r, fval(8'h21));
    host(1, 2'd2, 0, 0, 0, r); chk("R4 word2", r, fval(8'h22));
    host(1, 2'd1, 0, 0, 0, r); chk("R4 addr step", r, 32'h8C);
  endtask

  task automatic t_flush();
    host(0, 2'd1, 0, 0, 32'h200, r);
    host(1, 2'd2, 0, 0, 0, r); chk("R6 after addr write", r, fval(8'h80));
    host(1, 2'd3, 0, 0, 0, r); chk("R6 fixed read", r, fval(8'h81));
    host(1, 2'd1, 0, 0, 0, r); chk("R6 addr kept", r, 32'h204);
  endtask

  task automatic t_ready();
    lat = 6;
    host(0, 2'd1, 0, 0, 32'h300, r);
    @(negedge clk); while (!hp_rdy) @(negedge clk);
    hp_cs = 1; hp_strobe = 1; hp_rnw = 0; hp_sel = 2'd3; hp_wdata = 32'h0BAD_F00D;
    @(negedge clk); hp_cs = 0; hp_strobe = 0;
    chk("R10 rdy low while pending", 32'(hp_rdy), 0);
    repeat (3) @(negedge clk);
    chk("R11 request held", 32'(mem_req_valid), 1);
    while (!hp_rdy) @(negedge clk);
    chk("R10 write landed", mem[8'hC0], 32'h0BAD_F00D);
    lat = 2;
  endtask

  task automatic t_half();
    cfg_mode = 2'd0;
    host(0, 2'd1, 0, 0, 32'h0300, r);
    host(0, 2'd1, 1, 0, 32'h0000, r);
    host(1, 2'd1, 0, 0, 0, r); chk("R7 addr low half", r, 32'h0300);
    host(1, 2'd1, 1, 0, 0, r); chk("R7 addr high half", r, 32'h0000);
    snap = n_wr;
    host(0, 2'd3, 0, 0, 32'hFFFF5678, r);
    repeat (4) @(negedge clk);
    chk("R7 no write after first half", 32'(n_wr - snap), 0);
    host(0, 2'd3, 1, 0, 32'hFFFF1234, r);
    chk("R7 assembled word", mem[8'hC0], 32'h12345678);
  endtask

  task automatic t_half_read();
    snap = n_rd;
    host(1, 2'd3, 0, 0, 0, r); chk("R8 low half", r, 32'h5678);
    host(1, 2'd3, 1, 0, 0, r); chk("R8 high half", r, 32'h1234);
    chk("R8 single fetch", 32'(n_rd - snap), 1);
    cfg_mode = 2'd1;
  endtask

  task automatic t_window();
    host(0, 2'd0, 0, 0, 32'h5A, r);
    cfg_mode = 2'd2;
    host(0, 2'd1, 0, 16'h0010, 32'hCAFE0009, r);
    chk("R9 write addr", 32'(last_wr), 32'h5A0010);
    chk("R9 write data", mem[8'h04], 32'hCAFE0009);
    host(1, 2'd2, 0, 16'h0010, 0, r);
    chk("R9 read data", r, 32'hCAFE0009);
    chk("R9 read addr", 32'(last_rd), 32'h5A0010);
    cfg_mode = 2'd1;
    host(1, 2'd1, 0, 0, 0, r); chk("R9 addr reg untouched", r, 32'h300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_full_write();
    t_stream();
    t_flush();
    t_ready();
    t_half();
    t_half_read();
    t_window();
    chk("R10 ready during pending", 32'(v_rdy), 0);
    chk("R11 stall hold", 32'(v_hold), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule